// File: doc/BRIEF.md
# Constant-Switching Mismatch Shaper

This block drives a bank of N equally weighted unit elements of a multi-level converter. For every incoming sample it decides which elements are on. The number of elements on always equals the requested code. The number of elements that change state from the previous sample is held at a fixed target K wherever the code allows it. Because every sample produces about the same number of edges, the switching activity of each element no longer depends on the signal. About half of those edges are turn-ons, so each element sees an average transition density of K/(2N). Static mismatch is still shaped, because each element carries its own first-order loop filter that steers the selection.

For each sample the block first plans how many off elements to turn on and how many on elements to turn off. It then ranks the two groups separately. The off elements with the largest loop values are turned on, and the on elements with the smallest loop values are turned off. Ranking runs one pick per fast-clock cycle. When all picks are done, the new element vector is published with a one-cycle valid pulse and every loop filter is updated.

The achievable switching rate per element can never exceed min(d, 1−d) for an element usage density d. Near full scale the planner therefore clips the change count.

Top module: `csdem_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `elem_out` is all zeros and `out_valid` is low. All loop filter values are zero after reset.
- R2: On every `out_valid` pulse, the number of ones in `elem_out` equals the accepted code (after the clamp of R10).
- R3: Let p be the number of elements on before the sample, y the code and d = y − p. The number of turn-offs is b = floor((K − d)/2), clamped to the range [max(0, −d), min(p, N − y)]. The number of turn-ons is b + d. The number of bits of `elem_out` that differ from the previous published vector is exactly 2b + d.
- R4: Turn-ons go to the originally-off elements with the highest loop value, one at a time. On a tie the lower index wins.
- R5: Turn-offs go to the originally-on elements with the lowest loop value, one at a time. On a tie the lower index wins.
- R6: After each sample, each element's loop value (a signed ACC_W-bit number in units of 1/N) has y − N·s added to it, where s is that element's new state. The sum saturates at the signed ACC_W limits.
- R7: A strobe accepted at clock edge e0 produces `out_valid` high for exactly one cycle, after edge e0 + c + 1, where c = 2b + d is the change count of R3.
- R8: A strobe that arrives while a sample is still being processed is ignored. It affects neither the current result nor any later one.
- R9: `elem_out` holds its value in every cycle in which `out_valid` is low.
- R10: A code above N is treated as N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; ranking runs one pick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Sample request; accepted only when the block is idle |
| in_code | input | $clog2(N+1) (6) | Requested number of active elements |
| elem_out | output | N (32) | Element on/off vector, one bit per unit element |
| out_valid | output | 1 | One-cycle pulse marking a newly published vector |

## Verification
The result of a sample is due exactly c + 1 edges after the accepting edge, where c is the change count the bench derives from the code and the number of elements on. The bench therefore knows in advance the one cycle where `out_valid` must rise. The bench samples on falling edges. In every cycle between the strobe and one cycle after the pulse it compares `out_valid` and `elem_out` against a behavioural model: the old vector is expected until the pulse, and the new vector from the pulse on. On some samples a second strobe is raised in the cycle just after acceptance, and the model ignores it, so any effect of that strobe shows up as a mismatch in the same cycle-exact comparison.

// File: rtl/csdem_pkg.sv
package csdem_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PICK = 1'b1
    } csdem_state_e;

    // Clamp an integer into [lo, hi]
    function automatic int clamp_int(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/csdem_planner.sv
module csdem_planner #(
    parameter int N      = 32,
    parameter int K      = 8,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] ones,
    output logic [CODE_W-1:0] n_on,
    output logic [CODE_W-1:0] n_off,
    output logic [CODE_W-1:0] total
);
    import csdem_pkg::*;

    int delta;
    int want_off;
    int lo_off;
    int hi_off;
    int sel_off;

    always_comb begin
        delta    = int'(code) - int'(ones);
        // floor((K - delta) / 2): arithmetic shift of a signed int
        want_off = (K - delta) >>> 1;
        lo_off   = (delta < 0) ? -delta : 0;
        hi_off   = (int'(ones) < (N - int'(code))) ? int'(ones) : (N - int'(code));
        sel_off  = clamp_int(want_off, lo_off, hi_off);
        n_off    = CODE_W'(sel_off);
        n_on     = CODE_W'(sel_off + delta);
        total    = CODE_W'(2 * sel_off + delta);
    end

endmodule

// File: rtl/csdem_ranker.sv
module csdem_ranker #(
    parameter int N        = 32,
    parameter int ACC_W    = 12,
    parameter bit PICK_MAX = 1'b1,
    localparam int IDX_W   = $clog2(N)
) (
    input  logic [N*ACC_W-1:0] acc_flat,
    input  logic [N-1:0]       mask,
    output logic [IDX_W-1:0]   idx,
    output logic               found
);
    logic signed [ACC_W-1:0] best;
    logic signed [ACC_W-1:0] cand;
    logic                    better;

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        best   = '0;
        cand   = '0;
        better = 1'b0;
        for (int i = 0; i < N; i++) begin
            cand = acc_flat[i*ACC_W +: ACC_W];
            // strict compare keeps the lower index on ties
            better = PICK_MAX ? (cand > best) : (cand < best);
            if (mask[i] && (!found || better)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = cand;
            end
        end
    end

endmodule

// File: rtl/csdem_loopbank.sv
module csdem_loopbank #(
    parameter int N      = 32,
    parameter int ACC_W  = 12,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  logic [CODE_W-1:0]  code,
    input  logic [N-1:0]       new_state,
    output logic [N*ACC_W-1:0] acc_flat
);
    import csdem_pkg::*;

    localparam int ACC_MAX = (2 ** (ACC_W - 1)) - 1;
    localparam int ACC_MIN = -(2 ** (ACC_W - 1));

    for (genvar g = 0; g < N; g++) begin : g_elem
        logic signed [ACC_W-1:0] acc_r;
        int                      sum_v;

        always_comb begin
            sum_v = int'(acc_r) + int'(code) - (new_state[g] ? N : 0);
            sum_v = clamp_int(sum_v, ACC_MIN, ACC_MAX);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_r <= '0;
            end else if (upd) begin
                acc_r <= ACC_W'(sum_v);
            end
        end

        assign acc_flat[g*ACC_W +: ACC_W] = acc_r;
    end

endmodule

// File: rtl/csdem_top.sv
module csdem_top #(
    parameter int N       = 32,
    parameter int K       = 8,
    parameter int ACC_W   = 12,
    localparam int CODE_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_strobe,
    input  logic [CODE_W-1:0] in_code,
    output logic [N-1:0]      elem_out,
    output logic              out_valid
);
    import csdem_pkg::*;

    localparam int IDX_W = $clog2(N);

    csdem_state_e      state;
    logic [N-1:0]      elem_r;
    logic [N-1:0]      nxt_r;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] on_left;
    logic [CODE_W-1:0] off_left;
    logic [CODE_W-1:0] plan_total;
    logic              valid_r;

    logic [CODE_W-1:0] code_c;
    logic [CODE_W-1:0] ones_now;
    logic [CODE_W-1:0] plan_on;
    logic [CODE_W-1:0] plan_off;
    logic [CODE_W-1:0] plan_sum;
    logic [N*ACC_W-1:0] acc_flat;
    logic [IDX_W-1:0]  on_idx;
    logic [IDX_W-1:0]  off_idx;
    logic              on_found;
    logic              off_found;
    logic              busy;
    logic              upd;

    assign code_c   = (int'(in_code) > N) ? CODE_W'(N) : in_code;
    assign ones_now = CODE_W'($countones(elem_r));
    assign busy     = (state == ST_PICK);
    assign upd      = busy && (on_left == '0) && (off_left == '0);

    csdem_planner #(.N(N), .K(K), .CODE_W(CODE_W)) u_plan (
        .code  (code_c),
        .ones  (ones_now),
        .n_on  (plan_on),
        .n_off (plan_off),
        .total (plan_sum)
    );

    // off set ranked for turn-on (largest first)
    csdem_ranker #(.N(N), .ACC_W(ACC_W), .PICK_MAX(1'b1)) u_rank_on (
        .acc_flat (acc_flat),
        .mask     (~elem_r & ~nxt_r),
        .idx      (on_idx),
        .found    (on_found)
    );

    // on set ranked for turn-off (smallest first)
    csdem_ranker #(.N(N), .ACC_W(ACC_W), .PICK_MAX(1'b0)) u_rank_off (
        .acc_flat (acc_flat),
        .mask     (elem_r & nxt_r),
        .idx      (off_idx),
        .found    (off_found)
    );

    csdem_loopbank #(.N(N), .ACC_W(ACC_W), .CODE_W(CODE_W)) u_loops (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .code      (code_q),
        .new_state (nxt_r),
        .acc_flat  (acc_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            elem_r     <= '0;
            nxt_r      <= '0;
            code_q     <= '0;
            on_left    <= '0;
            off_left   <= '0;
            plan_total <= '0;
            valid_r    <= 1'b0;
        end else begin
            valid_r <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_strobe) begin
                        code_q     <= code_c;
                        on_left    <= plan_on;
                        off_left   <= plan_off;
                        plan_total <= plan_sum;
                        nxt_r      <= elem_r;
                        state      <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (on_left != '0 && on_found) begin
                        nxt_r[on_idx] <= 1'b1;
                        on_left       <= on_left - CODE_W'(1);
                    end else if (off_left != '0 && off_found) begin
                        nxt_r[off_idx] <= 1'b0;
                        off_left       <= off_left - CODE_W'(1);
                    end else begin
                        on_left  <= '0;
                        off_left <= '0;
                        elem_r   <= nxt_r;
                        valid_r  <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign elem_out  = elem_r;
    assign out_valid = valid_r;

endmodule

// File: rtl/csdem_chk.sv
module csdem_chk #(
    parameter int N      = 32,
    parameter int CODE_W = $clog2(N + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_strobe,
    input logic              busy,
    input logic [N-1:0]      elem_out,
    input logic              out_valid,
    input logic [CODE_W-1:0] code_q,
    input logic [CODE_W-1:0] plan_total
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (elem_out == '0 && !out_valid))
        else $error("R1 outputs not cleared by reset");

    a_r2_count_match: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(elem_out) == int'(code_q)))
        else $error("R2 active count differs from code");

    a_r3_change_count: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(elem_out ^ $past(elem_out)) == int'(plan_total)))
        else $error("R3 change count differs from plan");

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid)
        else $error("R7 valid longer than one cycle");

    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && in_strobe) |=> $stable(code_q))
        else $error("R8 strobe accepted while busy");

    a_r9_hold_vector: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(elem_out))
        else $error("R9 vector moved without valid");

endmodule

bind csdem_top csdem_chk #(.N(N), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_strobe  (in_strobe),
    .busy       (busy),
    .elem_out   (elem_out),
    .out_valid  (out_valid),
    .code_q     (code_q),
    .plan_total (plan_total)
);

// File: tb/tb_csdem_top.sv
module tb_csdem_top;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 32;
    localparam int K      = 8;
    localparam int ACC_W  = 6;
    localparam int CODE_W = $clog2(N + 1);
    localparam int ACC_MAX = (2 ** (ACC_W - 1)) - 1;
    localparam int ACC_MIN = -(2 ** (ACC_W - 1));

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_strobe = 1'b0;
    logic [CODE_W-1:0] in_code = '0;
    logic [N-1:0]      elem_out;
    logic              out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural model state
    int           m_acc[N];
    logic [N-1:0] m_vec = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csdem_top #(.N(N), .K(K), .ACC_W(ACC_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_strobe (in_strobe),
        .in_code   (in_code),
        .elem_out  (elem_out),
        .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int floor_half(int x);
        if (x >= 0) return x / 2;
        return -((-x + 1) / 2);
    endfunction

    // One sample through the model: returns the new vector and change count
    task automatic model_step(input int code, output logic [N-1:0] newv, output int chg, output int y);
        int p, d, b, a, lo, hi, best;
        y  = (code > N) ? N : code;                       // R10
        p  = $countones(m_vec);
        d  = y - p;
        lo = (d < 0) ? -d : 0;
        hi = (p < N - y) ? p : N - y;
        b  = floor_half(K - d);                           // R3
        if (b < lo) b = lo;
        if (b > hi) b = hi;
        a  = b + d;
        newv = m_vec;
        for (int n = 0; n < a; n++) begin                 // R4
            best = -1;
            for (int i = 0; i < N; i++)
                if (!m_vec[i] && !newv[i] && (best < 0 || m_acc[i] > m_acc[best])) best = i;
            newv[best] = 1'b1;
        end
        for (int n = 0; n < b; n++) begin                 // R5
            best = -1;
            for (int i = 0; i < N; i++)
                if (m_vec[i] && newv[i] && (best < 0 || m_acc[i] < m_acc[best])) best = i;
            newv[best] = 1'b0;
        end
        for (int i = 0; i < N; i++) begin                 // R6 saturating update
            m_acc[i] = m_acc[i] + y - (newv[i] ? N : 0);
            if (m_acc[i] > ACC_MAX) m_acc[i] = ACC_MAX;
            if (m_acc[i] < ACC_MIN) m_acc[i] = ACC_MIN;
        end
        chg   = a + b;
        m_vec = newv;
    endtask

    task automatic send(input int code, input bit inject);
        logic [N-1:0] oldv, expv;
        int c, y;
        oldv = m_vec;
        model_step(code, expv, c, y);
        @(negedge clk);
        in_strobe = 1'b1;
        in_code   = CODE_W'(code);
        @(negedge clk);                                   // after accepting edge
        if (inject) begin
            in_strobe = 1'b1;                             // R8: busy strobe
            in_code   = CODE_W'((code + 7) % (N + 1));
        end else begin
            in_strobe = 1'b0;
        end
        check(out_valid == 1'b0, "R7 no early valid", 64'(out_valid), 64'd0);
        check(elem_out == oldv, "R9 hold while busy", 64'(elem_out), 64'(oldv));
        for (int j = 1; j <= c + 1; j++) begin
            @(negedge clk);
            in_strobe = 1'b0;
            if (j <= c) begin
                check(out_valid == 1'b0, "R7 valid timing", 64'(out_valid), 64'd0);
                check(elem_out == oldv, "R9 hold while busy", 64'(elem_out), 64'(oldv));
            end else begin
                check(out_valid == 1'b1, "R7 valid due", 64'(out_valid), 64'd1);
                check(elem_out == expv, inject ? "R4,R5,R6,R8 vector" : "R4,R5,R6 vector",
                      64'(elem_out), 64'(expv));
                check($countones(elem_out) == y, "R2 count", 64'($countones(elem_out)), 64'(y));
                check($countones(elem_out ^ oldv) == c, "R3 changes",
                      64'($countones(elem_out ^ oldv)), 64'(c));
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R7 single pulse", 64'(out_valid), 64'd0);
        check(elem_out == expv, "R9 hold after valid", 64'(elem_out), 64'(expv));
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_acc[i] = 0;
        repeat (3) @(negedge clk);
        check(elem_out == '0, "R1 reset vector", 64'(elem_out), 64'd0);
        check(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(elem_out == '0 && out_valid == 1'b0, "R1 after reset", 64'(elem_out), 64'd0);

        send(5, 1'b0);
        check(elem_out == 32'h0000_001F, "R4 ties to lower index", 64'(elem_out), 64'h1F);
        send(5, 1'b0);
        send(10, 1'b1);
        send(0, 1'b0);
        check(elem_out == '0, "R2 zero code", 64'(elem_out), 64'd0);
        send(40, 1'b0);
        check(elem_out == '1, "R10 code above N", 64'(elem_out), 64'hFFFF_FFFF);
        send(63, 1'b1);
        send(31, 1'b0);
        send(16, 1'b0);
        send(16, 1'b1);
        send(1, 1'b0);
        send(1, 1'b0);
        for (int s = 0; s < 400; s++) begin
            send(int'($urandom_range(0, N + 3)), (s % 3) == 0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule